// File: doc/BRIEF.md
# Page Table Run Fill Engine

This block is a hardware sequencer that writes a contiguous span of page table entries for one physically contiguous mapping. A single start pulse captures the whole job: the first entry index, the number of entries, the base physical address, a memory type, the access mode, the page-size shift, an optional carve-out base in system memory, and the compression tag parameters. The engine then walks the span without further help. It emits every 64-bit entry as two 32-bit words on a valid/ready write stream.

The span is cut into runs. Each run is the largest naturally aligned power-of-two group of entries, up to 128, that still fits in what remains. Every entry of a run carries the same two words. The low word encodes the run's size exponent, so a translation unit can treat the run as one large page. After each run, the physical address and the compression offset advance by the run's span. When compression is enabled, each run gets its own tag.

The write stream follows the usual rules for back-pressure. A word transfers on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the engine holds the offered address and data unchanged and keeps `wr_valid` high. The engine never withdraws a word it has offered. `busy` and `done` are plain control pins.

Top module: `pte_run_filler`

## Requirements
- R1: `start` is accepted only while the engine is idle, and on acceptance all job inputs are captured. Changing the inputs afterwards has no effect. `busy` is high from the cycle after `start` until the last word has been accepted. Two cycles after the last word is accepted, `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R2: A job with a count of zero issues no write and raises `done` two cycles after `start`.
- R3: Entry n is written as two words: the low half at word address 2n, then the high half at word address 2n+1. Words go out in strictly ascending address order, starting at twice the first entry index.
- R4: The low word is the OR of the following fields:
  - physical address bits 31:0;
  - 1 at bit 0 (present);
  - the target at bits 5:4;
  - 1 at bit 3 unless the mode is write-only;
  - 1 at bit 6 when the mode is system memory;
  - the run's size exponent at bits 9:7.
- R5: The high word holds physical address bits 39:32 at bits 7:0 and the 9-bit memory type at bits 16:8, which is entry bit 40 upward.
- R6: A nonzero carve-out base is added to the physical address and sets the target to 3. A zero carve-out base leaves the address unchanged and gives target 0.
- R7: Each run has 2^e entries. e is the largest value from 7 down to 0 for which 2^e entries fit in the remaining count and the current entry index is a multiple of 2^e.
- R8: All entries of a run carry identical words. Between runs, the physical address advances by the run's entry count shifted left by the page-size shift.
- R9: The compression factor is memory type bits 8:7. When the factor is nonzero, high word bits 31:17 are (tag base + (offset >> 16) * factor) mod 2^15, and the offset advances per run like the address. When the factor is zero, those bits are 0.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R11: A `start` pulse while the engine is busy is ignored, and the running job continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, sampled while idle |
| start_idx | input | 16 | First entry index |
| count | input | 16 | Number of entries to write |
| phys_base | input | 40 | Physical byte address of the first page |
| stolen_base | input | 40 | Carve-out base in system memory, 0 for none |
| mem_type | input | 9 | Memory type; bits 8:7 are the compression factor |
| acc_sys | input | 1 | Access mode is system memory |
| acc_wo | input | 1 | Access mode is write-only |
| page_shift | input | 5 | log2 of the page size in bytes |
| tag_base | input | 15 | Compression tag base |
| comp_offset | input | 40 | Initial compression offset in bytes |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Sink accepts the offered word |
| wr_addr | output | 17 | 32-bit word address |
| wr_data | output | 32 | Word data |

## Verification
The hardest case to reach from the ports is a run of 128 entries, exponent 7, that contains back-pressure stalls and that starts or ends next to smaller runs. Reaching it needs a count of at least 128 at an index aligned to 128. Long jobs at indices 0, 5 and 127 drive the splitter from small runs up to full-size runs and back down. A pseudo-random `wr_ready` pattern stalls both halves of an entry. A sweep of every first index from 0 to 17 against every count from 0 to 19 covers all mixes of alignment and remainder below 32, and it varies the carve-out, access mode, shift and compression factor. In some jobs a second `start` is raised mid-run while `wr_ready` is held low, so the ignored pulse cannot hide behind a transfer.

// File: rtl/pte_fill_pkg.sv
package pte_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAN = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } fill_state_e;

  localparam int WORD_W    = 32;
  localparam int MT_LSB    = 40;  // memory type position inside the 64-bit entry
  localparam int EXP_LSB   = 7;   // run exponent position in the low word
  localparam int TAG_LSB   = 17;  // tag position in the high word
  localparam int CF_LSB    = 7;   // compression factor position in memory type
  localparam int TGT_LSB   = 4;
  localparam int RW_BIT    = 3;
  localparam int SYS_BIT   = 6;
  localparam logic [1:0] TGT_CARVE = 2'd3;
  localparam logic [1:0] TGT_LOCAL = 2'd0;
endpackage

// File: rtl/pte_run_sizer.sv
module pte_run_sizer #(
  parameter int IDX_W   = 16,
  parameter int CNT_W   = 16,
  parameter int MAX_EXP = 7,
  localparam int EXP_W  = $clog2(MAX_EXP + 1),
  localparam int RUN_W  = MAX_EXP + 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] remain,
  output logic [EXP_W-1:0] run_exp,
  output logic [RUN_W-1:0] run_len
);
  logic [MAX_EXP:0] fits;

  for (genvar e = 0; e <= MAX_EXP; e++) begin : g_fit
    localparam logic [CNT_W-1:0] SPAN = CNT_W'(1) << e;
    localparam logic [IDX_W-1:0] LOWM = (IDX_W'(1) << e) - IDX_W'(1);
    assign fits[e] = (remain >= SPAN) && ((idx & LOWM) == '0);
  end

  // highest fitting exponent wins
  always_comb begin
    run_exp = '0;
    for (int e = 0; e <= MAX_EXP; e++) begin
      if (fits[e]) run_exp = EXP_W'(e);
    end
  end

  assign run_len = RUN_W'(1) << run_exp;
endmodule

// File: rtl/pte_tag_calc.sv
module pte_tag_calc #(
  parameter int PA_W  = 40,
  parameter int TAG_W = 15
) (
  input  logic [TAG_W-1:0] tag_base,
  input  logic [PA_W-1:0]  offset,
  input  logic [1:0]       factor,
  output logic [TAG_W-1:0] tag
);
  logic [PA_W-1:0] page64k;
  logic [PA_W+1:0] prod;

  assign page64k = offset >> 16;
  assign prod    = {2'b00, page64k} * {{PA_W{1'b0}}, factor};
  assign tag     = tag_base + prod[TAG_W-1:0];
endmodule

// File: rtl/pte_word_encoder.sv
module pte_word_encoder
  import pte_fill_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int MT_W  = 9,
  parameter int EXP_W = 3,
  parameter int TAG_W = 15
) (
  input  logic [PA_W-1:0]   phys,
  input  logic [MT_W-1:0]   mem_type,
  input  logic [1:0]        target,
  input  logic              acc_sys,
  input  logic              acc_wo,
  input  logic [EXP_W-1:0]  run_exp,
  input  logic [TAG_W-1:0]  tag,
  input  logic              tag_en,
  output logic [WORD_W-1:0] lo_word,
  output logic [WORD_W-1:0] hi_word
);
  logic [2*WORD_W-1:0] entry;

  always_comb begin
    entry = 64'(phys) | 64'(1);
    entry = entry | (64'(mem_type) << MT_LSB);
    entry = entry | (64'(target) << TGT_LSB);
    if (acc_sys) entry[SYS_BIT] = 1'b1;
    if (!acc_wo) entry[RW_BIT]  = 1'b1;
  end

  assign lo_word = entry[WORD_W-1:0] | (WORD_W'(run_exp) << EXP_LSB);
  assign hi_word = entry[2*WORD_W-1:WORD_W] |
                   (tag_en ? (WORD_W'(tag) << TAG_LSB) : '0);
endmodule

// File: rtl/pte_run_filler.sv
module pte_run_filler
  import pte_fill_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int CNT_W   = 16,
  parameter int PA_W    = 40,
  parameter int MT_W    = 9,
  parameter int SHIFT_W = 5,
  parameter int MAX_EXP = 7,
  localparam int ADDR_W = IDX_W + 1,
  localparam int EXP_W  = $clog2(MAX_EXP + 1),
  localparam int RUN_W  = MAX_EXP + 1,
  localparam int WCNT_W = MAX_EXP + 2,
  localparam int TAG_W  = WORD_W - TAG_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic [CNT_W-1:0]   count,
  input  logic [PA_W-1:0]    phys_base,
  input  logic [PA_W-1:0]    stolen_base,
  input  logic [MT_W-1:0]    mem_type,
  input  logic               acc_sys,
  input  logic               acc_wo,
  input  logic [SHIFT_W-1:0] page_shift,
  input  logic [TAG_W-1:0]   tag_base,
  input  logic [PA_W-1:0]    comp_offset,
  output logic               busy,
  output logic               done,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data
);
  fill_state_e        state;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   rem_q;
  logic [PA_W-1:0]    phys_q;
  logic [PA_W-1:0]    offs_q;
  logic [MT_W-1:0]    mt_q;
  logic               sys_q, wo_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [1:0]         tgt_q;
  logic [TAG_W-1:0]   tagb_q;
  logic [WORD_W-1:0]  lo_q, hi_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               half_q;
  logic [WCNT_W-1:0]  words_q;

  logic [EXP_W-1:0]   run_exp;
  logic [RUN_W-1:0]   run_len;
  logic [TAG_W-1:0]   run_tag;
  logic [1:0]         factor;
  logic [WORD_W-1:0]  enc_lo, enc_hi;
  logic [PA_W-1:0]    run_step;

  assign factor   = mt_q[CF_LSB +: 2];
  assign run_step = PA_W'(run_len) << shift_q;

  pte_run_sizer #(.IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_EXP(MAX_EXP)) u_sizer (
    .idx(idx_q), .remain(rem_q), .run_exp(run_exp), .run_len(run_len)
  );

  pte_tag_calc #(.PA_W(PA_W), .TAG_W(TAG_W)) u_tag (
    .tag_base(tagb_q), .offset(offs_q), .factor(factor), .tag(run_tag)
  );

  pte_word_encoder #(.PA_W(PA_W), .MT_W(MT_W), .EXP_W(EXP_W), .TAG_W(TAG_W)) u_enc (
    .phys(phys_q), .mem_type(mt_q), .target(tgt_q), .acc_sys(sys_q),
    .acc_wo(wo_q), .run_exp(run_exp), .tag(run_tag), .tag_en(factor != 2'b00),
    .lo_word(enc_lo), .hi_word(enc_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      phys_q  <= '0;
      offs_q  <= '0;
      mt_q    <= '0;
      sys_q   <= 1'b0;
      wo_q    <= 1'b0;
      shift_q <= '0;
      tgt_q   <= TGT_LOCAL;
      tagb_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      addr_q  <= '0;
      half_q  <= 1'b0;
      words_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            idx_q   <= start_idx;
            rem_q   <= count;
            phys_q  <= phys_base + stolen_base;
            tgt_q   <= (stolen_base != '0) ? TGT_CARVE : TGT_LOCAL;
            offs_q  <= comp_offset;
            mt_q    <= mem_type;
            sys_q   <= acc_sys;
            wo_q    <= acc_wo;
            shift_q <= page_shift;
            tagb_q  <= tag_base;
            addr_q  <= {start_idx, 1'b0};
            half_q  <= 1'b0;
            state   <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (rem_q == '0) begin
            state <= ST_FIN;
          end else begin
            lo_q    <= enc_lo;
            hi_q    <= enc_hi;
            words_q <= {run_len, 1'b0} - WCNT_W'(1);
            idx_q   <= idx_q + IDX_W'(run_len);
            rem_q   <= rem_q - CNT_W'(run_len);
            phys_q  <= phys_q + run_step;
            offs_q  <= offs_q + run_step;
            state   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (wr_ready) begin
            addr_q  <= addr_q + ADDR_W'(1);
            half_q  <= ~half_q;
            words_q <= words_q - WCNT_W'(1);
            if (words_q == '0) state <= ST_PLAN;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_PLAN) || (state == ST_EMIT);
  assign done     = (state == ST_FIN);
  assign wr_valid = (state == ST_EMIT);
  assign wr_addr  = addr_q;
  assign wr_data  = half_q ? hi_q : lo_q;

  // R10: a stalled word stays on offer unchanged
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R1: done is a single-cycle pulse with busy low
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: an accepted low half is followed at once by its high half
  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_addr[0]) |=> (wr_valid && wr_addr[0]));

  // R4: every low word carries the present flag
  assert_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_addr[0]) |-> wr_data[0]);

  // R7: a chosen run is aligned and fits in what remains
  assert_run_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLAN && rem_q != '0) |->
      (((idx_q & (IDX_W'(run_len) - IDX_W'(1))) == '0) && (CNT_W'(run_len) <= rem_q)));

  // R2: nothing left means completion with no write offered
  assert_empty_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLAN && rem_q == '0) |=> (done && !wr_valid));
endmodule

// File: tb/pte_run_filler_test.sv
module pte_run_filler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_idx = '0;
  logic [15:0] count = '0;
  logic [39:0] phys_base = '0;
  logic [39:0] stolen_base = '0;
  logic [8:0]  mem_type = '0;
  logic        acc_sys = 1'b0;
  logic        acc_wo = 1'b0;
  logic [4:0]  page_shift = '0;
  logic [14:0] tag_base = '0;
  logic [39:0] comp_offset = '0;
  logic        busy, done, wr_valid;
  logic        wr_ready = 1'b0;
  logic [16:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit rnd_ready = 1'b0;

  always #10 clk = ~clk;

  pte_run_filler uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx), .count(count),
    .phys_base(phys_base), .stolen_base(stolen_base), .mem_type(mem_type),
    .acc_sys(acc_sys), .acc_wo(acc_wo), .page_shift(page_shift), .tag_base(tag_base),
    .comp_offset(comp_offset), .busy(busy), .done(done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit next_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return rnd_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
  endfunction

  // Waits for one word transfer and compares it with the expected word.
  task automatic expect_word(input logic [16:0] ea, input logic [31:0] ed,
                             input bit inject, output bit dead);
    bit stalled = 1'b0;
    logic [16:0] sa = '0;
    logic [31:0] sd = '0;
    int waited = 0;
    dead = 1'b0;
    if (inject) begin
      // R11: a start raised mid-run with the sink stalled
      wr_ready = 1'b0;
      start = 1'b1;
      start_idx = 16'h0003;
      count = 16'h0001;
      @(negedge clk);
      start = 1'b0;
    end
    forever begin
      wr_ready = next_ready();
      if (stalled) begin
        chk(wr_valid && wr_addr == sa && wr_data == sd, "R10", "stall hold",
            {15'b0, wr_addr, wr_data}, {15'b0, sa, sd});
        stalled = 1'b0;
      end
      if (wr_valid && wr_ready) break;
      if (wr_valid) begin
        stalled = 1'b1;
        sa = wr_addr;
        sd = wr_data;
      end
      chk(busy && !done, "R1", "busy while words remain", {62'b0, busy, done}, 64'd2);
      waited++;
      if (waited > 2000) begin
        chk(1'b0, "R3", "word never offered", 64'd0, {15'b0, ea, ed});
        dead = 1'b1;
        return;
      end
      @(negedge clk);
    end
    chk(wr_addr == ea, "R3", "word address", 64'(wr_addr), 64'(ea));
    chk(wr_data == ed, "R4/R5/R8/R9", "word data", 64'(wr_data), 64'(ed));
    @(negedge clk);
  endtask

  task automatic run_case(input int s_idx, input int n, input logic [39:0] base,
                          input logic [39:0] stolen, input logic [8:0] mt,
                          input bit sys, input bit wo, input int shift,
                          input logic [14:0] tagb, input logic [39:0] offs,
                          input bit inject);
    logic [39:0] p;
    logic [39:0] d;
    logic [1:0]  tgt;
    logic [1:0]  cf;
    int ci, rem, e, nw;
    bit dead;
    p   = base + stolen;
    d   = offs;
    tgt = (stolen != 0) ? 2'd3 : 2'd0;   // R6
    cf  = mt[8:7];
    ci  = s_idx;
    rem = n;
    nw  = 0;
    dead = 1'b0;

    @(negedge clk);
    start = 1'b1;
    start_idx = 16'(s_idx);
    count = 16'(n);
    phys_base = base;
    stolen_base = stolen;
    mem_type = mt;
    acc_sys = sys;
    acc_wo = wo;
    page_shift = 5'(shift);
    tag_base = tagb;
    comp_offset = offs;
    @(negedge clk);
    start = 1'b0;
    // R1: inputs are captured at start; scrambling them now must not matter
    start_idx = 16'h7777;
    count = 16'h0005;
    phys_base = 40'hFF_FFFF_F000;
    stolen_base = 40'h0;
    mem_type = ~mt;
    acc_sys = ~sys;
    acc_wo = ~wo;
    page_shift = 5'd20;
    tag_base = ~tagb;
    comp_offset = ~offs;
    chk(busy && !done && !wr_valid, "R1", "busy after start",
        {61'b0, busy, done, wr_valid}, 64'd4);

    while (rem > 0 && !dead) begin
      logic [31:0] lo, hi;
      logic [31:0] tag;
      // R7: largest aligned power of two that fits, capped at 2^7
      e = 0;
      for (int k = 7; k >= 0; k--) begin
        if (rem >= (1 << k) && (ci % (1 << k)) == 0) begin
          e = k;
          break;
        end
      end
      tag = (32'(tagb) + 32'(d >> 16) * 32'(cf)) & 32'h7FFF;
      lo = p[31:0] | 32'h1 | (32'(tgt) << 4) | (sys ? 32'h40 : 32'h0) |
           (wo ? 32'h0 : 32'h8) | (32'(e) << 7);
      hi = {24'b0, p[39:32]} | (32'(mt) << 8) | ((cf != 0) ? (tag << 17) : 32'h0);
      for (int k = 0; k < (1 << e) && !dead; k++) begin
        for (int h = 0; h < 2 && !dead; h++) begin
          expect_word(17'((ci + k) * 2 + h), (h == 0) ? lo : hi,
                      inject && nw == 3, dead);
          nw++;
        end
      end
      // R8/R9: advance by the run span
      p = p + (40'(1 << e) << shift);
      d = d + (40'(1 << e) << shift);
      ci = ci + (1 << e);
      rem = rem - (1 << e);
    end
    if (dead) return;
    // one cycle in the planning state, then the done pulse (R1, R2)
    chk(busy && !done && !wr_valid, "R2", "planning after last word",
        {61'b0, busy, done, wr_valid}, 64'd4);
    @(negedge clk);
    chk(done && !busy && !wr_valid, "R1", "done pulse", {61'b0, busy, done, wr_valid}, 64'd2);
    @(negedge clk);
    chk(!done && !busy, "R1", "done is one cycle", {62'b0, busy, done}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !wr_valid, "R1", "reset state",
        {61'b0, busy, done, wr_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid, "R1", "idle after reset",
        {61'b0, busy, done, wr_valid}, 64'd0);

    // R2: empty job, both carve-out settings
    run_case(9, 0, 40'h00_0004_0000, 40'h0, 9'h011, 1'b0, 1'b0, 12, 15'h0, 40'h0, 1'b0);
    run_case(0, 0, 40'h00_0004_0000, 40'h10_0000_0000, 9'h011, 1'b1, 1'b1, 16, 15'h0, 40'h0, 1'b0);

    // R3..R11: sweep of first index against count
    for (int si = 0; si < 18; si++) begin
      for (int n = 0; n < 20; n++) begin
        logic [39:0] stl;
        logic [8:0]  mt;
        stl = (si % 3 == 0) ? 40'h0 : 40'h10_0000_0000;
        mt = 9'((si * 37 + n * 11) & 9'h1FF);
        rnd_ready = ((si + n) % 2) == 1;
        run_case(si, n, 40'h00_1234_5000 + (40'(si) << 20), stl, mt,
                 ((si ^ n) & 1) == 1, ((n >> 1) & 1) == 1, (n % 2 == 1) ? 16 : 12,
                 15'(si * 1000 + 7), 40'(si * n) << 16, (si == 5 || si == 12) && n >= 4);
      end
    end

    // R7/R9: long jobs reaching runs of 128 with compression and stalls
    rnd_ready = 1'b1;
    run_case(5, 300, 40'h00_8000_0000, 40'h0, 9'h1A5, 1'b1, 1'b0, 16, 15'h7FF0, 40'h3_0000, 1'b0);
    run_case(0, 256, 40'h01_0000_0000, 40'h10_0000_0000, 9'h0C2, 1'b0, 1'b1, 12, 15'h0100, 40'h0, 1'b1);
    rnd_ready = 1'b0;
    run_case(127, 130, 40'h00_0000_0000, 40'h0, 9'h080, 1'b0, 1'b0, 16, 15'h0001, 40'hF_0000, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule